// File: doc/BRIEF.md
# Programmable multi-bank clock divider

The block takes one fast source clock and derives four clock groups from it: three output banks of four lanes each (A, B, C) and a single feedback output. Each group has its own even divide ratio, picked with a small select field. All four dividers are cleared by one shared reset and advance on one shared enable, so their rising edges stay coincident wherever the ratios line up. An optional divide-by-two ahead of the dividers halves the source rate.

The active-low master reset doubles as the output enable. While it is low the counters are held clear, every output floats, and the select inputs and the source-rate control are captured. While it is high the captured setup is frozen. A separate polarity control inverts the two upper lanes of bank C.

Top module: `clkDivBanks`

## Requirements
- R1: Bank A divides the tick rate by 4, 6, 8 or 12 for ratioSelA = 0, 1, 2 or 3.
- R2: Bank B divides the tick rate by 4, 6, 8 or 10 for ratioSelB = 0, 1, 2 or 3.
- R3: Bank C divides the tick rate by 2, 4, 6 or 8 for ratioSelC = 0, 1, 2 or 3.
- R4: The feedback output divides by 4, 6, 8 or 10 for ratioSelFb[1:0] = 0, 1, 2 or 3 when ratioSelFb[2] is 0, and by twice those values (8, 12, 16, 20) when ratioSelFb[2] is 1.
- R5: A group of ratio N, after its tick number j (j = 0 for the first tick after reset release), outputs 1 exactly when (j mod N) < N/2, giving a 50% duty cycle. All four lanes of a bank carry the same value, apart from the inversion of R9.
- R6: With srcDirect = 1 every source clock edge is a tick. With srcDirect = 0 the first edge after release is a tick and after that every second edge, so all ratios are doubled.
- R7: On the first source edge after rstN rises, all groups start in step. After that edge every output is 1.
- R8: While rstN is low, all 13 outputs are high impedance (an immediate, combinational effect) and the dividers are cleared. The select fields and srcDirect are captured on every edge with rstN low. Changes to them while rstN is high have no effect until the next reset.
- R9: When invC is 1, bankC[3] and bankC[2] are the inverse of bankC[1:0]. When invC is 0 all four lanes are equal. The control acts combinationally and is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Active-low master reset and output enable |
| srcDirect | input | 1 | 1: dividers advance on every edge; 0: on every second edge |
| ratioSelA | input | 2 | Bank A ratio select |
| ratioSelB | input | 2 | Bank B ratio select |
| ratioSelC | input | 2 | Bank C ratio select |
| ratioSelFb | input | 3 | Feedback ratio select; bit 2 doubles the ratio |
| invC | input | 1 | Inverts bankC[3:2] when 1 |
| bankA | output | 4 | Bank A outputs |
| bankB | output | 4 | Bank B outputs |
| bankC | output | 4 | Bank C outputs |
| fbOut | output | 1 | Feedback output |

## Verification
Each divider output is a register updated on the source edge that carries a tick. The value for a given edge therefore appears right after that edge and is sampled at the following falling edge, against a model that counts edges since release. The high-impedance state and the bank C inversion are combinational, so they are checked at the falling edge of the same cycle in which the bench changed rstN or invC. Select changes made while running are checked by confirming that the outputs keep following the setup captured during the last reset.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CNT_W = 5;

  typedef struct packed {
    logic [1:0] selA;
    logic [1:0] selB;
    logic [1:0] selC;
    logic [2:0] selFb;
    logic       direct;
  } divCfg_t;

  typedef struct packed {
    logic clear;
    logic tick;
  } divStrobe_t;

  function automatic logic [CNT_W-1:0] decodeA(input logic [1:0] s);
    case (s)
      2'd0: decodeA = CNT_W'(4);
      2'd1: decodeA = CNT_W'(6);
      2'd2: decodeA = CNT_W'(8);
      default: decodeA = CNT_W'(12);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decodeB(input logic [1:0] s);
    case (s)
      2'd0: decodeB = CNT_W'(4);
      2'd1: decodeB = CNT_W'(6);
      2'd2: decodeB = CNT_W'(8);
      default: decodeB = CNT_W'(10);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decodeC(input logic [1:0] s);
    decodeC = CNT_W'({s, 1'b0}) + CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] decodeFb(input logic [2:0] s);
    logic [CNT_W-1:0] base;
    base = CNT_W'({s[1:0], 1'b0}) + CNT_W'(4);
    decodeFb = s[2] ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/divCtrl.sv
`timescale 1ns/1ps
module divCtrl
  import clkdiv_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  divCfg_t                     cfgIn,
  output divCfg_t                     cfg,
  output divStrobe_t                  strobe,
  output logic [GROUPS-1:0][CNT_W-1:0] ratios
);
  logic oddPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= cfgIn;
      oddPhase <= 1'b0;
    end else begin
      oddPhase <= ~oddPhase;
    end
  end

  always_comb begin
    strobe.clear = !rstN;
    strobe.tick  = rstN && (cfg.direct || !oddPhase);
  end

  always_comb begin
    ratios    = '0;
    ratios[0] = decodeA(cfg.selA);
    ratios[1] = decodeB(cfg.selB);
    ratios[2] = decodeC(cfg.selC);
    ratios[3] = decodeFb(cfg.selFb);
  end
endmodule

// File: rtl/divCounter.sv
`timescale 1ns/1ps
module divCounter
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] ratio,
  output logic             q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             wrap;

  assign half = ratio >> 1;
  assign wrap = (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (strobe.tick) begin
      q   <= (cnt < half);
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/divDatapath.sv
`timescale 1ns/1ps
module divDatapath
  import clkdiv_pkg::*;
#(
  parameter int GROUPS = 4
) (
  input  logic                         clk,
  input  divStrobe_t                   strobe,
  input  logic [GROUPS-1:0][CNT_W-1:0] ratios,
  output logic [GROUPS-1:0]            qGrp
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_div
    divCounter u_cnt (
      .clk    (clk),
      .strobe (strobe),
      .ratio  (ratios[g]),
      .q      (qGrp[g])
    );
  end
endmodule

// File: rtl/clkDivBanks.sv
`timescale 1ns/1ps
module clkDivBanks
  import clkdiv_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcDirect,
  input  logic [1:0]       ratioSelA,
  input  logic [1:0]       ratioSelB,
  input  logic [1:0]       ratioSelC,
  input  logic [2:0]       ratioSelFb,
  input  logic             invC,
  output logic [LANES-1:0] bankA,
  output logic [LANES-1:0] bankB,
  output logic [LANES-1:0] bankC,
  output logic             fbOut
);
  localparam int GROUPS  = 4;
  localparam int INV_LO  = LANES - 2;

  divCfg_t                      cfgIn;
  divCfg_t                      cfg;
  divStrobe_t                   ctlS;
  logic [GROUPS-1:0][CNT_W-1:0] ratios;
  logic [GROUPS-1:0]            qGrp;
  logic [LANES-1:0]             invMask;
  logic [LANES-1:0]             cVal;

  assign cfgIn = '{selA: ratioSelA, selB: ratioSelB, selC: ratioSelC,
                   selFb: ratioSelFb, direct: srcDirect};

  divCtrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgIn  (cfgIn),
    .cfg    (cfg),
    .strobe (ctlS),
    .ratios (ratios)
  );

  divDatapath #(.GROUPS(GROUPS)) u_dp (
    .clk    (clk),
    .strobe (ctlS),
    .ratios (ratios),
    .qGrp   (qGrp)
  );

  always_comb begin
    invMask = '0;
    for (int i = INV_LO; i < LANES; i++) invMask[i] = invC;
  end

  assign cVal  = {LANES{qGrp[2]}} ^ invMask;
  assign bankA = rstN ? {LANES{qGrp[0]}} : {LANES{1'bz}};
  assign bankB = rstN ? {LANES{qGrp[1]}} : {LANES{1'bz}};
  assign bankC = rstN ? cVal : {LANES{1'bz}};
  assign fbOut = rstN ? qGrp[3] : 1'bz;
endmodule

// File: rtl/clkDivBanks_chk.sv
`timescale 1ns/1ps
module clkDivBanks_chk
  import clkdiv_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             invC,
  input logic [LANES-1:0] bankA,
  input logic [LANES-1:0] bankC,
  input logic             tick,
  input logic             direct,
  input divCfg_t          cfg,
  input logic [3:0]       qGrp
);
  p_align_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !$past(rstN)) |=> (&qGrp));

  p_half_rate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!direct && tick) |=> !tick);

  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && $past(rstN)) |=> $stable(qGrp));

  p_lanes_equal_r5: assert property (@(posedge clk) disable iff (!rstN)
    bankA[LANES-1] == bankA[0]);

  p_c_invert_r9: assert property (@(posedge clk) disable iff (!rstN)
    bankC[LANES-1] == (bankC[0] ^ invC));

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(cfg));
endmodule

bind clkDivBanks clkDivBanks_chk #(.LANES(LANES)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .invC   (invC),
  .bankA  (bankA),
  .bankC  (bankC),
  .tick   (ctlS.tick),
  .direct (cfg.direct),
  .cfg    (cfg),
  .qGrp   (qGrp)
);

// File: tb/clkDivBanks_tb_top.sv
`timescale 1ns/1ps
module clkDivBanks_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srcDirect = 1'b1;
  logic [1:0] selA = '0, selB = '0, selC = '0;
  logic [2:0] selFb = '0;
  logic invC = 1'b0;
  wire [3:0] aW, bW, cW;
  wire fbW;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int edgeIdx = -1;
  int mA = 0, mB = 0, mC = 0, mF = 0, mD = 1;
  bit changed = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g_pu
    pullup pa (aW[i]);
    pullup pb (bW[i]);
    pullup pc (cW[i]);
  end
  pullup pf (fbW);

  clkDivBanks dut_i (
    .clk(clk), .rstN(rstN), .srcDirect(srcDirect),
    .ratioSelA(selA), .ratioSelB(selB), .ratioSelC(selC),
    .ratioSelFb(selFb), .invC(invC),
    .bankA(aW), .bankB(bW), .bankC(cW), .fbOut(fbW)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      edgeIdx = -1;
      mA = selA; mB = selB; mC = selC; mF = selFb; mD = srcDirect;
      changed = 0;
    end else begin
      edgeIdx = edgeIdx + 1;
    end
  end

  function automatic int ratioA(int s);
    case (s) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
  endfunction
  function automatic int ratioB(int s);
    case (s) 0: return 4; 1: return 6; 2: return 8; default: return 10; endcase
  endfunction
  function automatic int ratioC(int s);
    case (s) 0: return 2; 1: return 4; 2: return 6; default: return 8; endcase
  endfunction
  function automatic int ratioF(int s);
    int b;
    case (s % 4) 0: b = 4; 1: b = 6; 2: b = 8; default: b = 10; endcase
    return (s >= 4) ? 2 * b : b;
  endfunction

  function automatic logic waveAt(int n, int j);
    return ((j % n) < (n / 2));
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b edge=%0d", tag, act, exp, edgeIdx);
    end
  endtask

  task automatic compareAll();
    int j;
    string sfx;
    logic [3:0] ec;
    if (!rstN || edgeIdx < 0) begin
      chk("R8 hiz bankA", aW, 4'hF);
      chk("R8 hiz bankB", bW, 4'hF);
      chk("R8 hiz bankC", cW, 4'hF);
      chk("R8 hiz fbOut", {3'b000, fbW}, 4'h1);
      return;
    end
    j = mD ? edgeIdx : (edgeIdx / 2);
    sfx = "";
    if (!mD) sfx = {sfx, " R6"};
    if (edgeIdx == 0) sfx = {sfx, " R7"};
    if (changed) sfx = {sfx, " R8"};
    chk({"R1 R5", sfx}, aW, {4{waveAt(ratioA(mA), j)}});
    chk({"R2 R5", sfx}, bW, {4{waveAt(ratioB(mB), j)}});
    ec = {4{waveAt(ratioC(mC), j)}} ^ {invC, invC, 2'b00};
    chk({"R3 R9", sfx}, cW, ec);
    chk({"R4 R5", sfx}, {3'b000, fbW}, {3'b000, waveAt(ratioF(mF), j)});
  endtask

  initial begin
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rstN = 1'b0;
      selA = 2'(i); selB = 2'(i + 1); selC = 2'(i + 2); selFb = 3'(i);
      srcDirect = ((i % 3) != 0);
      invC = i[0];
      repeat (3) begin
        @(negedge clk);
        compareAll();
      end
      rstN = 1'b1;
      #0.1;
      if (edgeIdx < 0) begin
        // combinational release: outputs driven again, counters still clear
        chk("R8 release drives bankA", aW, 4'h0);
      end
      for (int c = 0; c < 130; c++) begin
        @(negedge clk);
        compareAll();
        if (c == 40) invC = ~invC;
        if (c == 60) begin
          selA = ~selA; selB = ~selB; selC = ~selC; selFb = ~selFb;
          srcDirect = ~srcDirect;
          changed = 1;
        end
        if (c == 95) invC = ~invC;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule